// File: doc/BRIEF.md
# ADC Result Window Monitor

This block inspects every fresh conversion result from an analog-to-digital converter and tests it against two programmable bounds, a floor and a ceiling. One of four window tests is picked by a 2-bit select: below the floor, above the ceiling, within the closed window, or outside it. The test outcome is registered into a live condition output suitable for driving a pin. The same outcome feeds a sticky interrupt flag that only sets when the interrupt is enabled.

Software programs the bounds, the test and the enable, and leaves them alone while results stream in. It then either watches the condition output or waits for the flag and writes a clear. The converter, register decoding and pin routing sit outside this block.

Top module: `adc_window_mon`

## Requirements
- R1: After reset, `cond_o` and `irq_o` are both 0.
- R2: With `mode_i` = 2'b00 (below), a valid result sets the condition to 1 exactly when `result_i < floor_i`.
- R3: With `mode_i` = 2'b01 (above), a valid result sets the condition to 1 exactly when `result_i > ceil_i`.
- R4: With `mode_i` = 2'b10 (within), a valid result sets the condition to 1 exactly when `floor_i <= result_i <= ceil_i`. Both bounds are inclusive.
- R5: With `mode_i` = 2'b11 (outside), a valid result sets the condition to 1 exactly when `result_i < floor_i` or `result_i > ceil_i`.
- R6: `cond_o` updates one cycle after a cycle with `valid_i` high. When `valid_i` is low, it holds its value.
- R7: `irq_o` sets one cycle after a valid result whose condition is true, but only if `irq_en_i` is high. With `irq_en_i` low, `irq_o` is not set.
- R8: `irq_o` stays set until `irq_clr_i` is asserted. It then reads 0 from the next cycle, unless a new trigger arrives in that same cycle, in which case it stays 1.
- R9: When `floor_i > ceil_i`, the within test is never true and the outside test is true for every result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | New result strobe |
| result_i | input | RES_W | Conversion result |
| floor_i | input | RES_W | Lower bound |
| ceil_i | input | RES_W | Upper bound |
| mode_i | input | 2 | Test select: 00 below, 01 above, 10 within, 11 outside |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Interrupt clear |
| cond_o | output | 1 | Registered monitor condition |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The assertions assume that `mode_i`, `floor_i` and `ceil_i` hold steady from a valid strobe until the edge that captures it. They also assume all inputs are known out of reset. The bench changes configuration only in cycles that have no valid strobe. Each random result is paired with the bounds in force in that cycle, and directed cases cover equality at each bound and inverted bounds.

// File: rtl/adc_window_mon_pkg.sv
package adc_window_mon_pkg;
  typedef enum logic [1:0] {
    TEST_BELOW   = 2'b00,
    TEST_ABOVE   = 2'b01,
    TEST_WITHIN  = 2'b10,
    TEST_OUTSIDE = 2'b11
  } win_test_e;

  typedef struct packed {
    logic below;
    logic above;
  } cmp_flags_t;
endpackage

// File: rtl/adc_win_compare.sv
module adc_win_compare #(
  parameter int RES_W = 12
) (
  input  logic [RES_W-1:0]              result_i,
  input  logic [RES_W-1:0]              floor_i,
  input  logic [RES_W-1:0]              ceil_i,
  output adc_window_mon_pkg::cmp_flags_t flags_o
);
  function automatic logic is_less(input logic [RES_W-1:0] a, input logic [RES_W-1:0] b);
    return a < b;
  endfunction

  always_comb begin
    flags_o.below = is_less(result_i, floor_i);
    flags_o.above = is_less(ceil_i, result_i);
  end
endmodule

// File: rtl/adc_win_select.sv
module adc_win_select (
  input  adc_window_mon_pkg::cmp_flags_t flags_i,
  input  logic [1:0]                     mode_i,
  output logic                           hit_o
);
  import adc_window_mon_pkg::*;

  function automatic logic pick(input cmp_flags_t f, input logic [1:0] m);
    case (win_test_e'(m))
      TEST_BELOW:  return f.below;
      TEST_ABOVE:  return f.above;
      TEST_WITHIN: return !(f.below || f.above);
      default:     return f.below || f.above;
    endcase
  endfunction

  assign hit_o = pick(flags_i, mode_i);
endmodule

// File: rtl/adc_win_irq.sv
module adc_win_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic clr_i,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     irq_o <= 1'b0;
    else if (trig_i) irq_o <= 1'b1;
    else if (clr_i)  irq_o <= 1'b0;
  end

  // R8
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> irq_o);

  // R8
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !trig_i) |=> !irq_o);

  // R7
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> irq_o);
endmodule

// File: rtl/adc_window_mon.sv
module adc_window_mon #(
  parameter int RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [RES_W-1:0] result_i,
  input  logic [RES_W-1:0] floor_i,
  input  logic [RES_W-1:0] ceil_i,
  input  logic [1:0]       mode_i,
  input  logic             irq_en_i,
  input  logic             irq_clr_i,
  output logic             cond_o,
  output logic             irq_o
);
  import adc_window_mon_pkg::*;

  cmp_flags_t flags;
  logic       hit;
  logic       irq_trig;

  adc_win_compare #(.RES_W(RES_W)) u_cmp (
    .result_i(result_i), .floor_i(floor_i), .ceil_i(ceil_i), .flags_o(flags)
  );

  adc_win_select u_sel (.flags_i(flags), .mode_i(mode_i), .hit_o(hit));

  assign irq_trig = valid_i && hit && irq_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cond_o <= 1'b0;
    else if (valid_i) cond_o <= hit;
  end

  adc_win_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(irq_trig),
    .clr_i(irq_clr_i), .irq_o(irq_o)
  );

  // R6
  cond_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cond_o));

  // R7
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !irq_en_i) |=> !irq_o);

  // R9
  inverted_within_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && floor_i > ceil_i && mode_i == 2'b10) |=> !cond_o);

  // R9
  inverted_outside_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && floor_i > ceil_i && mode_i == 2'b11) |=> cond_o);

  // R2
  below_disjoint_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flags.below && result_i >= floor_i));
endmodule

// File: tb/adc_window_mon_bench.sv
module adc_window_mon_bench;
  localparam int RES_W = 12;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, valid = 1'b0, en = 1'b0, clr = 1'b0;
  logic [RES_W-1:0] res = '0, lo = '0, hi = '0;
  logic [1:0] mode = 2'b00;
  logic cond, irq;
  int vecs = 0, errs = 0;
  logic exp_cond = 1'b0, exp_irq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_window_mon #(.RES_W(RES_W)) u_adc_window_mon (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .result_i(res),
    .floor_i(lo), .ceil_i(hi), .mode_i(mode), .irq_en_i(en),
    .irq_clr_i(clr), .cond_o(cond), .irq_o(irq)
  );

  function automatic logic ref_hit(input int r, input int l, input int h, input int m);
    case (m)
      0: return r < l;
      1: return r > h;
      2: return (r >= l) && (r <= h);
      default: return !((r >= l) && (r <= h));
    endcase
  endfunction

  function automatic string tag_of(input int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string rq, input logic act, input logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %b expected %b", rq, act, exp);
    end
  endtask

  task automatic apply(input logic v, input int r, input logic c, input string rq);
    @(negedge clk);
    valid = v; res = RES_W'(r); clr = c;
    if (v) exp_cond = ref_hit(r, int'(lo), int'(hi), int'(mode));
    if (v && exp_cond && en) exp_irq = 1'b1;
    else if (c) exp_irq = 1'b0;
    @(negedge clk);
    valid = 1'b0; clr = 1'b0;
    check({rq, " cond"}, cond, exp_cond);
    check({rq, " irq"}, irq, exp_irq);
  endtask

  task automatic cfg(input int l, input int h, input int m, input logic e);
    @(negedge clk);
    lo = RES_W'(l); hi = RES_W'(h); mode = 2'(m); en = e;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1
    check("R1 cond", cond, 1'b0);
    check("R1 irq", irq, 1'b0);
    rst_n = 1'b1;

    cfg(100, 200, 0, 1'b0);
    apply(1, 99, 0, "R2"); apply(1, 100, 0, "R2");
    cfg(100, 200, 1, 1'b0);
    apply(1, 200, 0, "R3"); apply(1, 201, 0, "R3");
    cfg(100, 200, 2, 1'b0);
    apply(1, 100, 0, "R4"); apply(1, 200, 0, "R4"); apply(1, 99, 0, "R4"); apply(1, 201, 0, "R4");
    cfg(100, 200, 3, 1'b0);
    apply(1, 99, 0, "R5"); apply(1, 150, 0, "R5"); apply(1, 201, 0, "R5");
    // R6: hold with no strobe, then after a change
    apply(0, 150, 0, "R6");
    apply(1, 150, 0, "R6");
    apply(0, 5, 0, "R6");
    // R7: enable gating
    cfg(100, 200, 3, 1'b0);
    apply(1, 5, 0, "R7");
    cfg(100, 200, 3, 1'b1);
    apply(1, 5, 0, "R7");
    // R8: sticky, clear, clear colliding with trigger
    apply(1, 150, 0, "R8");
    apply(0, 0, 1, "R8");
    apply(1, 5, 1, "R8");
    apply(0, 0, 1, "R8");
    // R9: inverted bounds
    cfg(300, 100, 2, 1'b0);
    apply(1, 200, 0, "R9"); apply(1, 100, 0, "R9"); apply(1, 300, 0, "R9");
    cfg(300, 100, 3, 1'b0);
    apply(1, 200, 0, "R9"); apply(1, 50, 0, "R9");

    for (int i = 0; i < 400; i++) begin
      int m;
      m = int'($urandom_range(3));
      cfg(int'($urandom_range(4095)), int'($urandom_range(4095)), m, 1'($urandom_range(1)));
      apply(1'($urandom_range(3) != 0), int'($urandom_range(4095)),
            1'($urandom_range(1)), tag_of(m));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    vecs++; errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule